// File: doc/BRIEF.md
# Dual-Field Montgomery Multiplier

This block forms the Montgomery product of two operands, a·b·R⁻¹ with R = 2^(N+2), over either a prime field or a binary polynomial field. Both fields share one datapath. Operand `op_a` is kept whole. Operand `op_b` is consumed one bit per iteration, least significant bit first. Each iteration conditionally adds `op_a`, conditionally adds the modulus so that the low bit becomes zero, and then shifts right by one. The loop runs N+2 times.

In prime mode the accumulator is held in carry-save form, as a sum vector plus a carry vector, so that no iteration waits on a carry chain. After the last iteration, the first carry-save level is reused as a half-adder. It folds the carry vector into the sum until the carry vector is empty. In binary mode the carries are gated off, so the same adders reduce to XOR and no conversion is needed.

With the extra two iterations, prime-mode results stay below twice the modulus. Such a result can be fed straight back in as an operand. The host supplies operands that are already in Montgomery form and does any domain conversion itself.

Top module: `dfmont_mul`

## Requirements
- R1: In prime mode (`mode` = 0), for an odd modulus p < 2^N and operands below 2p, the result r satisfies r·2^(N+2) ≡ a·b (mod p).
- R2: In prime mode the result is strictly below 2p.
- R3: In binary mode (`mode` = 1), `modulus` holds a polynomial f of degree N with bit N and bit 0 set, and the operands have degree below N. The result r then satisfies r·x^(N+2) ≡ a·b (mod f), with carry-free arithmetic.
- R4: In binary mode bit N of the result is zero, so the result has degree below N.
- R5: In binary mode `done` rises exactly N+2 clock cycles after the edge that accepts `start`.
- R6: In prime mode `done` rises no earlier than N+3 and no later than 2N+6 cycles after the accepting edge.
- R7: `done` is high for exactly one cycle per accepted `start`. A `start` raised while a product is in progress is ignored: it changes neither that product's result nor its timing, and it produces no second `done`.
- R8: While the block is idle and `start` is low, `result` holds its last value regardless of changes on the operand inputs.
- R9: While reset is active and in the cycle after it, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a product; accepted only while idle |
| mode | input | 1 | Field select: 0 prime, 1 binary polynomial |
| op_a | input | N+1 | Multiplicand, held whole |
| op_b | input | N+1 | Multiplier, scanned bit by bit |
| modulus | input | N+1 | Odd prime or degree-N polynomial |
| done | output | 1 | One-cycle completion pulse |
| result | output | N+1 | Montgomery product, valid from `done` |

## Verification
The bench counts cycles from the edge that accepts `start`. It checks for `done` at each falling edge. A binary-mode product must arrive at exactly count N+2. A prime-mode product must arrive within the window from N+3 to 2N+6, because the conversion length depends on how far the carries ripple. The result is checked on the falling edge where `done` is first seen, and the next falling edge must show `done` low again. Result hold is checked two cycles after new values are placed on the operand inputs while `start` stays low.

// File: rtl/mm_pkg.sv
package mm_pkg;

    // Field selection as seen on the mode pin
    typedef enum logic {
        FM_PRIME = 1'b0,
        FM_BIN   = 1'b1
    } fmode_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CONV = 2'd2
    } mm_state_e;

    // Strobes handed from the sequencer to the datapath
    typedef struct packed {
        logic load;
        logic run;
        logic conv;
        logic busy;
    } mm_ctl_t;

    function automatic logic carries_on(fmode_e m);
        return m == FM_PRIME;
    endfunction

endpackage

// File: rtl/mm_csa_step.sv
module mm_csa_step #(
    parameter int W = 19
) (
    input  logic [W-1:0] s,
    input  logic [W-1:0] cv,
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         bi,
    input  logic         carry_en,
    input  logic         conv,
    output logic [W-1:0] s_n,
    output logic [W-1:0] cv_n
);
    logic [W-1:0] x, t, k, y, u, k2;
    logic         q;

    always_comb begin
        // first level: accumulator plus gated multiplicand
        x = bi ? a : '0;
        t = s ^ cv ^ x;
        k = carry_en ? (((s & cv) | (s & x) | (cv & x)) << 1) : '0;
        // quotient bit: low bit of the redundant sum (k[0] is always 0)
        q = t[0] & ~conv;
        y = q ? m : '0;
        // second level: add the modulus multiple
        u  = t ^ k ^ y;
        k2 = carry_en ? (((t & k) | (t & y) | (k & y)) << 1) : '0;
        if (conv) begin
            // half-adder reuse of the first level, no shift
            s_n  = t;
            cv_n = k;
        end else begin
            // low bit of u is zero, exact halving
            s_n  = u >> 1;
            cv_n = k2 >> 1;
        end
    end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  fmode_e  mode_q,
    input  logic    cv_zero,
    output mm_ctl_t ctl,
    output logic    done
);
    localparam int ITERS = N + 2;
    localparam int CW    = $clog2(ITERS);
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    mm_state_e     st;
    logic [CW-1:0] cnt;

    always_comb begin
        ctl.load = (st == ST_IDLE) && start;
        ctl.run  = (st == ST_RUN);
        ctl.conv = (st == ST_CONV) && !cv_zero;
        ctl.busy = (st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        if (carries_on(mode_q)) begin
                            st <= ST_CONV;
                        end else begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (cv_zero) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dfmont_mul.sv
module dfmont_mul
    import mm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         mode,
    input  logic [N:0]   op_a,
    input  logic [N:0]   op_b,
    input  logic [N:0]   modulus,
    output logic         done,
    output logic [N:0]   result
);
    localparam int W  = N + 1;
    localparam int AW = N + 3;
    localparam int BW = N + 2;

    logic [AW-1:0] s_q, cv_q, a_q, m_q, s_n, cv_n;
    logic [BW-1:0] b_q;
    fmode_e        mode_q;
    mm_ctl_t       ctl;
    logic          cv_zero, busy;

    assign cv_zero = (cv_q == '0);
    assign busy    = ctl.busy;

    mm_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode_q  (mode_q),
        .cv_zero (cv_zero),
        .ctl     (ctl),
        .done    (done)
    );

    mm_csa_step #(.W(AW)) u_step (
        .s        (s_q),
        .cv       (cv_q),
        .a        (a_q),
        .m        (m_q),
        .bi       (ctl.run & b_q[0]),
        .carry_en (carries_on(mode_q)),
        .conv     (ctl.conv),
        .s_n      (s_n),
        .cv_n     (cv_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            cv_q   <= '0;
            a_q    <= '0;
            m_q    <= '0;
            b_q    <= '0;
            mode_q <= FM_PRIME;
        end else if (ctl.load) begin
            s_q    <= '0;
            cv_q   <= '0;
            a_q    <= AW'(op_a);
            m_q    <= AW'(modulus);
            b_q    <= BW'(op_b);
            mode_q <= fmode_e'(mode);
        end else if (ctl.run) begin
            s_q  <= s_n;
            cv_q <= cv_n;
            b_q  <= b_q >> 1;
        end else if (ctl.conv) begin
            s_q  <= s_n;
            cv_q <= cv_n;
        end
    end

    assign result = s_q[W-1:0];
endmodule

// File: rtl/dfmont_mul_chk.sv
module dfmont_mul_chk
    import mm_pkg::*;
#(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         mode,
    input logic         busy,
    input logic         done,
    input logic [N:0]   result,
    input fmode_e       mode_q,
    input logic [N+2:0] m_q
);
    logic   trk;
    int     cnt;
    fmode_e md;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk <= 1'b0;
            cnt <= 0;
            md  <= FM_PRIME;
        end else if (start && !busy) begin
            trk <= 1'b1;
            cnt <= 0;
            md  <= fmode_e'(mode);
        end else if (done) begin
            trk <= 1'b0;
        end else if (trk) begin
            cnt <= cnt + 1;
        end
    end

    // R9
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!done && result == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_owned_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> trk);

    // R5
    bin_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (done && md == FM_BIN) |-> cnt == N + 2);

    // R6
    prime_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (done && md == FM_PRIME) |-> (cnt >= N + 3 && cnt <= 2 * N + 6));

    // R2
    prime_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == FM_PRIME) |-> ((N+4)'(result) < ((N+4)'(m_q) << 1)));

    // R4
    bin_degree_chk: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == FM_BIN) |-> !result[N]);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));
endmodule

bind dfmont_mul dfmont_mul_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .result (result),
    .mode_q (mode_q),
    .m_q    (m_q)
);

// File: tb/dfmont_mul_tb_top.sv
module dfmont_mul_tb_top;
    localparam int N   = 16;
    localparam int W   = N + 1;
    localparam int LIM = 2 * N + 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, modulus = '0;
    logic         done;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dfmont_mul #(.N(N)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode    (mode),
        .op_a    (op_a),
        .op_b    (op_b),
        .modulus (modulus),
        .done    (done),
        .result  (result)
    );

    task automatic chk(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned clmul(longint unsigned x, longint unsigned y);
        longint unsigned r = 0;
        for (int i = 0; i < 32; i++)
            if (y[i]) r ^= x << i;
        return r;
    endfunction

    function automatic longint unsigned pmod(longint unsigned v, longint unsigned f);
        for (int i = 62; i >= N; i--)
            if (v[i]) v ^= f << (i - N);
        return v;
    endfunction

    task automatic run_op(input bit md, input longint unsigned a, input longint unsigned b,
                          input longint unsigned m, input bit poke);
        int lat;
        longint unsigned r, lhs, rhs;
        logic [W-1:0] held;
        @(negedge clk);
        mode = md; op_a = W'(a); op_b = W'(b); modulus = W'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < LIM) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 3) begin
                start = 1'b1; op_a = ~W'(a); op_b = ~W'(b); mode = ~md;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        r = longint'(result);
        if (md) begin
            chk(lat == N + 2, "R5 binary latency", lat, N + 2);
            lhs = pmod(r << (N + 2), m);
            rhs = pmod(clmul(a, b), m);
            chk(lhs == rhs, "R3 binary product", lhs, rhs);
            chk(result[N] == 1'b0, "R4 binary degree", r, r & ((1 << N) - 1));
        end else begin
            chk(lat >= N + 3 && lat <= 2 * N + 6, "R6 prime latency", lat, N + 3);
            lhs = (r << (N + 2)) % m;
            rhs = (a * b) % m;
            chk(lhs == rhs, "R1 prime product", lhs, rhs);
            chk(r < 2 * m, "R2 prime bound", r, 2 * m);
        end
        @(negedge clk);
        chk(done == 1'b0, "R7 done single pulse", done, 0);
        held = result;
        op_a = W'($urandom); op_b = W'($urandom); modulus = W'($urandom); mode = ~mode;
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0 && result == held, "R8 result hold / R7 no second run",
            longint'(result), longint'(held));
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint unsigned p, f, a, b;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && result == '0, "R9 reset state", longint'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && result == '0, "R9 after reset", longint'(result), 0);

        // directed prime corners (R1, R2, R6)
        run_op(1'b0, 0, 12345, 65521, 1'b0);
        run_op(1'b0, 2 * 65521 - 1, 2 * 65521 - 1, 65521, 1'b0);
        run_op(1'b0, 2 * 65535 - 1, 2 * 65535 - 1, 65535, 1'b0);
        run_op(1'b0, 1, 1, 3, 1'b0);
        // directed binary corners (R3, R4, R5)
        run_op(1'b1, 0, 16'hBEEF, 17'h1002B, 1'b0);
        run_op(1'b1, 1, 1, 17'h1002B, 1'b0);
        run_op(1'b1, 16'hFFFF, 16'hFFFF, 17'h1FFFF, 1'b0);
        // start while busy is ignored (R7)
        run_op(1'b0, 777, 4321, 40503, 1'b1);
        run_op(1'b1, 16'h1234, 16'hABCD, 17'h1002B, 1'b1);

        for (int i = 0; i < 40; i++) begin
            p = longint'($urandom & 32'hFFFF) | 1;
            if (p < 3) p = 3;
            a = longint'($urandom) % (2 * p);
            b = longint'($urandom) % (2 * p);
            run_op(1'b0, a, b, p, (i % 7) == 3);
            f = longint'($urandom & 32'hFFFF) | 1 | (1 << N);
            a = longint'($urandom & 32'hFFFF);
            b = longint'($urandom & 32'hFFFF);
            run_op(1'b1, a, b, f, (i % 9) == 4);
        end

        // chained prime product: feed a result back without reduction (R1, R2)
        p = 65519;
        run_op(1'b0, 2 * p - 2, 54321, p, 1'b0);
        a = longint'(result);
        run_op(1'b0, a, a, p, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule